// File: doc/BRIEF.md
# Address translation window unit

This block holds a small bank of programmable windows that a bus bridge uses to redirect accesses from one address space into another. Each window claims a naturally aligned source range, with a power-of-two size, and sends any address inside it to the same offset within a target range. Software programs the windows through a 32-bit register port. The bridge presents a source address on the lookup port and gets back, in the same cycle, whether a window claimed it, which window did, and the translated address.

One parameter selects the direction. The outbound build (processor to bus) has five windows. The inbound build (bus to processor) has three windows and a shifted register decode. Each window has a translation register, an extended translation register, a base register and an attribute register. Base and translation values are kept in 4 KiB pages, so lookup addresses are 44 bits wide. The attribute register carries an enable bit and a size exponent. Its other bits (prefetch hint, target select, snoop codes) are kept for software and have no effect on translation.

Top module: `atw_unit`

## Requirements
- R1: After reset every window register reads 0 and no lookup hits.
- R2: A window hits only while bit 31 of its attribute register is 1. Clearing that bit removes the window from lookup on the next cycle.
- R3: Attribute bits [5:0] hold a size exponent n, and the window covers 2^(n+1) bytes. The source address base+2^(n+1)-1 hits and base+2^(n+1) does not.
- R4: The base and translation registers hold 4 KiB page numbers. The byte address of each is the register value shifted left by 12 bits, within a 44-bit address space.
- R5: On a hit, the translated address takes the source address bits below the window size and the translation address bits above it.
- R6: When several enabled windows claim an address, the lowest window index is reported and used.
- R7: When no window hits, the hit output is 0, the window index is 0 and the translated address is 0.
- R8: In the outbound build, register address bits [7:5] select window 0 to 4. Writes that decode to index 5, 6 or 7 are ignored, and reads there return 0.
- R9: In the inbound build, the window index is register address bits [6:5] minus one, which gives three windows. Bit 7 is ignored, and writes with bits [6:5] equal to 0 are ignored.
- R10: Within a window, register address bits [4:0] select the register: 0x00 translation, 0x04 extended translation, 0x08 base, 0x10 attributes. Every other offset is ignored on write and reads as 0. Mapped registers read back the value last written.
- R11: Attribute bits other than 31 and [5:0] are stored and read back unchanged, and they do not alter the result of a lookup.
- R12: A register write becomes visible to lookup in the cycle after the write edge. After that edge the window's old mapping no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| lk_addr | input | 44 | Source address to translate |
| lk_hit | output | 1 | A window claimed the source address |
| lk_win | output | 3 | Index of the claiming window |
| lk_taddr | output | 44 | Translated address, 0 on a miss |

## Verification
Lookups probe the first and last byte of a window and the bytes just outside it on each side, which separates a correct size mask from one that is off by one power of two. Overlapping windows of different sizes are looked up in the shared region and in the region only the larger window covers, which tells the priority order apart from plain matching. Each address is looked up again after the base is moved, after the window is disabled and after the spare attribute bits are written, which shows whether a lookup uses the current or a stale mapping. Writes to unmapped offsets and indices, and to aliased inbound addresses, are read back to check the register decode for both builds.

// File: rtl/atw_pkg.sv
package atw_pkg;
    localparam int REG_W   = 32;
    localparam int PAGE_SH = 12;
    localparam int IDX_W   = 3;
    localparam int RA_W    = 8;
    localparam int SZ_W    = 6;
    localparam int EN_BIT  = 31;

    localparam logic [4:0] OFF_TAR  = 5'h00;
    localparam logic [4:0] OFF_TEXT = 5'h04;
    localparam logic [4:0] OFF_BASE = 5'h08;
    localparam logic [4:0] OFF_ATTR = 5'h10;
endpackage

// File: rtl/atw_regfile.sv
module atw_regfile
    import atw_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int INBOUND = 0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [RA_W-1:0]                 wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    input  logic [RA_W-1:0]                 rd_addr,
    output logic [REG_W-1:0]                rd_data,
    output logic [NUM_WIN-1:0][REG_W-1:0]   tar_q,
    output logic [NUM_WIN-1:0][REG_W-1:0]   base_q,
    output logic [NUM_WIN-1:0][REG_W-1:0]   attr_q
);
    logic [NUM_WIN-1:0][REG_W-1:0] text_q;
    logic             wr_ok, rd_ok;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    generate
        if (INBOUND != 0) begin : g_in_dec
            logic unused_hi;
            assign unused_hi = wr_addr[7] ^ rd_addr[7];
            assign wr_ok  = (wr_addr[6:5] != 2'd0);
            assign rd_ok  = (rd_addr[6:5] != 2'd0);
            assign wr_idx = {1'b0, wr_addr[6:5]} - 3'd1;
            assign rd_idx = {1'b0, rd_addr[6:5]} - 3'd1;
        end else begin : g_out_dec
            assign wr_ok  = (wr_addr[7:5] < IDX_W'(NUM_WIN));
            assign rd_ok  = (rd_addr[7:5] < IDX_W'(NUM_WIN));
            assign wr_idx = wr_addr[7:5];
            assign rd_idx = rd_addr[7:5];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tar_q  <= '0;
            text_q <= '0;
            base_q <= '0;
            attr_q <= '0;
        end else if (wr_en && wr_ok) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (wr_idx == IDX_W'(w)) begin
                    case (wr_addr[4:0])
                        OFF_TAR:  tar_q[w]  <= wr_data;
                        OFF_TEXT: text_q[w] <= wr_data;
                        OFF_BASE: base_q[w] <= wr_data;
                        OFF_ATTR: attr_q[w] <= wr_data;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (rd_idx == IDX_W'(w)) begin
                    case (rd_addr[4:0])
                        OFF_TAR:  rd_data = tar_q[w];
                        OFF_TEXT: rd_data = text_q[w];
                        OFF_BASE: rd_data = base_q[w];
                        OFF_ATTR: rd_data = attr_q[w];
                        default:  rd_data = '0;
                    endcase
                end
            end
        end
    end

    AST_ATTR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok && wr_idx == 3'd0 && wr_addr[4:0] == OFF_ATTR)
        |=> (attr_q[0] == $past(wr_data))); // R10
endmodule

// File: rtl/atw_match.sv
module atw_match
    import atw_pkg::*;
#(
    parameter int ADDR_W = 44
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [ADDR_W-1:0] tar_b,
    input  logic              en,
    input  logic [SZ_W-1:0]   sz,
    output logic              hit,
    output logic [ADDR_W-1:0] taddr
);
    logic [SZ_W:0]     span;
    logic [ADDR_W-1:0] mask;

    always_comb begin
        span = {1'b0, sz} + 7'd1;
        if (span >= 7'(ADDR_W)) mask = '1;
        else                    mask = (ADDR_W'(1) << span) - ADDR_W'(1);
        hit   = en && ((src & ~mask) == (base_b & ~mask));
        taddr = (tar_b & ~mask) | (src & mask);
    end
endmodule

// File: rtl/atw_select.sv
module atw_select
    import atw_pkg::*;
#(
    parameter int NUM_WIN = 5,
    parameter int ADDR_W  = 44
) (
    input  logic [NUM_WIN-1:0]             hit_vec,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] taddr_vec,
    output logic                           hit,
    output logic [IDX_W-1:0]               win,
    output logic [ADDR_W-1:0]              taddr
);
    always_comb begin
        hit   = 1'b0;
        win   = '0;
        taddr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit   = 1'b1;
                win   = IDX_W'(i);
                taddr = taddr_vec[i];
            end
        end
    end
endmodule

// File: rtl/atw_unit.sv
module atw_unit
    import atw_pkg::*;
#(
    parameter int INBOUND = 0,
    parameter int NUM_OUT = 5,
    parameter int NUM_IN  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr_en,
    input  logic [RA_W-1:0]           reg_wr_addr,
    input  logic [REG_W-1:0]          reg_wr_data,
    input  logic [RA_W-1:0]           reg_rd_addr,
    output logic [REG_W-1:0]          reg_rd_data,
    input  logic [REG_W+PAGE_SH-1:0]  lk_addr,
    output logic                      lk_hit,
    output logic [IDX_W-1:0]          lk_win,
    output logic [REG_W+PAGE_SH-1:0]  lk_taddr
);
    localparam int NUM_WIN = (INBOUND != 0) ? NUM_IN : NUM_OUT;
    localparam int ADDR_W  = REG_W + PAGE_SH;

    logic [NUM_WIN-1:0][REG_W-1:0]  tar_q, base_q, attr_q;
    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] taddr_vec;

    atw_regfile #(.NUM_WIN(NUM_WIN), .INBOUND(INBOUND)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .tar_q   (tar_q),
        .base_q  (base_q),
        .attr_q  (attr_q)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            logic [REG_W-SZ_W-2:0] unused_attr;
            assign unused_attr = attr_q[w][EN_BIT-1:SZ_W];
            atw_match #(.ADDR_W(ADDR_W)) u_match (
                .src    (lk_addr),
                .base_b ({base_q[w], {PAGE_SH{1'b0}}}),
                .tar_b  ({tar_q[w],  {PAGE_SH{1'b0}}}),
                .en     (attr_q[w][EN_BIT]),
                .sz     (attr_q[w][SZ_W-1:0]),
                .hit    (hit_vec[w]),
                .taddr  (taddr_vec[w])
            );
        end
    endgenerate

    atw_select #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_sel (
        .hit_vec   (hit_vec),
        .taddr_vec (taddr_vec),
        .hit       (lk_hit),
        .win       (lk_win),
        .taddr     (lk_taddr)
    );

    // Checker-side view of the reported window's attributes
    logic              sel_en;
    logic [SZ_W-1:0]   sel_sz;
    logic [ADDR_W-1:0] sel_mask;
    always_comb begin
        sel_en = 1'b0;
        sel_sz = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (lk_win == IDX_W'(w)) begin
                sel_en = attr_q[w][EN_BIT];
                sel_sz = attr_q[w][SZ_W-1:0];
            end
        end
        if (({1'b0, sel_sz} + 7'd1) >= 7'(ADDR_W)) sel_mask = '1;
        else sel_mask = (ADDR_W'(1) << ({1'b0, sel_sz} + 7'd1)) - ADDR_W'(1);
    end

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> sel_en); // R2
    AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_taddr == '0 && lk_win == '0)); // R7
    AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_win < IDX_W'(NUM_WIN))); // R6
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (((lk_taddr ^ lk_addr) & sel_mask) == '0)); // R5
endmodule

// File: tb/atw_unit_tb.sv
module atw_unit_tb;
    localparam int AW = 44;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          o_wr = 1'b0, i_wr = 1'b0;
    logic [7:0]    o_wa = '0, i_wa = '0, o_ra = '0, i_ra = '0;
    logic [31:0]   o_wd = '0, i_wd = '0;
    logic [31:0]   o_rd, i_rd;
    logic [AW-1:0] o_la = '0, i_la = '0;
    logic          o_hit, i_hit;
    logic [2:0]    o_win, i_win;
    logic [AW-1:0] o_ta, i_ta;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic          hit;
        logic [2:0]    win;
        logic [AW-1:0] taddr;
        string         tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    atw_unit #(.INBOUND(0)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(o_wr), .reg_wr_addr(o_wa), .reg_wr_data(o_wd),
        .reg_rd_addr(o_ra), .reg_rd_data(o_rd),
        .lk_addr(o_la), .lk_hit(o_hit), .lk_win(o_win), .lk_taddr(o_ta)
    );

    atw_unit #(.INBOUND(1)) u_dut_in (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(i_wr), .reg_wr_addr(i_wa), .reg_wr_data(i_wd),
        .reg_rd_addr(i_ra), .reg_rd_data(i_rd),
        .lk_addr(i_la), .lk_hit(i_hit), .lk_win(i_win), .lk_taddr(i_ta)
    );

    // Monitor: compares outbound lookup results against the scoreboard
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (o_hit !== e.hit || o_win !== e.win || o_ta !== e.taddr) begin
                n_fail++;
                $display("FAIL %s: got hit=%0b win=%0d taddr=%h, expected hit=%0b win=%0d taddr=%h",
                         e.tag, o_hit, o_win, o_ta, e.hit, e.win, e.taddr);
            end
        end
    end

    task automatic wr_out(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        o_wr = 1'b1; o_wa = a; o_wd = d;
        @(posedge clk); #1;
        o_wr = 1'b0;
    endtask

    task automatic wr_in(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        i_wr = 1'b1; i_wa = a; i_wd = d;
        @(posedge clk); #1;
        i_wr = 1'b0;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic h, input logic [2:0] w,
                          input logic [AW-1:0] t, input string tag);
        exp_t e;
        @(posedge clk); #1;
        o_la = a;
        e.hit = h; e.win = w; e.taddr = t; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic rd_out(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        o_ra = a;
        @(negedge clk);
        n_chk++;
        if (o_rd !== exp) begin
            n_fail++;
            $display("FAIL %s: read %h got %h expected %h", tag, a, o_rd, exp);
        end
    endtask

    task automatic rd_in(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        i_ra = a;
        @(negedge clk);
        n_chk++;
        if (i_rd !== exp) begin
            n_fail++;
            $display("FAIL %s: inbound read %h got %h expected %h", tag, a, i_rd, exp);
        end
    endtask

    task automatic look_in(input logic [AW-1:0] a, input logic h, input logic [2:0] w,
                           input logic [AW-1:0] t, input string tag);
        @(posedge clk); #1;
        i_la = a;
        @(negedge clk);
        n_chk++;
        if (i_hit !== h || i_win !== w || i_ta !== t) begin
            n_fail++;
            $display("FAIL %s: inbound got hit=%0b win=%0d taddr=%h, expected hit=%0b win=%0d taddr=%h",
                     tag, i_hit, i_win, i_ta, h, w, t);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_out(8'h10, 32'h0, "R1 attr after reset");
        rd_out(8'h00, 32'h0, "R1 tar after reset");
        lookup(44'h0, 1'b0, 3'd0, 44'h0, "R1 no hit after reset");

        // Window 0 programmed but not yet enabled (R2)
        wr_out(8'h00, 32'h0000_0100);
        wr_out(8'h08, 32'h0000_0040);
        lookup(44'h40010, 1'b0, 3'd0, 44'h0, "R2 disabled window");
        wr_out(8'h10, 32'h8000_000F);
        lookup(44'h40010, 1'b1, 3'd0, 44'h100010, "R5 translate in window");
        lookup(44'h4FFFF, 1'b1, 3'd0, 44'h10FFFF, "R3 last byte hits");
        lookup(44'h50000, 1'b0, 3'd0, 44'h0, "R3 one past end misses");
        lookup(44'h3FFFF, 1'b0, 3'd0, 44'h0, "R7 below base misses");

        // Window 1: larger window overlapping window 0 (R6)
        wr_out(8'h20, 32'h0000_0200);
        wr_out(8'h28, 32'h0000_0040);
        wr_out(8'h30, 32'h8000_0013);
        lookup(44'h40010, 1'b1, 3'd0, 44'h100010, "R6 lowest index wins");
        lookup(44'h80000, 1'b1, 3'd1, 44'h280000, "R5 upper bits from translation");

        // Window 4 at the top of the page space (R4)
        wr_out(8'h80, 32'h0000_0001);
        wr_out(8'h88, 32'hFFFF_FFFF);
        wr_out(8'h90, 32'h8000_000B);
        lookup(44'hFFFFFFFF123, 1'b1, 3'd4, 44'h1123, "R4 page shift top window");
        lookup(44'hFFFFFFFE123, 1'b0, 3'd0, 44'h0, "R4 neighbour page misses");

        // Index 5 ignored (R8)
        wr_out(8'hA8, 32'h0000_0300);
        wr_out(8'hB0, 32'h8000_000B);
        rd_out(8'hB0, 32'h0, "R8 index 5 attr reads 0");
        rd_out(8'hA8, 32'h0, "R8 index 5 base reads 0");
        lookup(44'h300010, 1'b0, 3'd0, 44'h0, "R8 index 5 never hits");

        // Offset decode (R10)
        wr_out(8'h44, 32'h0000_DEAD);
        wr_out(8'h4C, 32'h0000_1234);
        rd_out(8'h44, 32'h0000_DEAD, "R10 extended readback");
        rd_out(8'h4C, 32'h0, "R10 unmapped offset reads 0");
        rd_out(8'h40, 32'h0, "R10 neighbour unaffected");
        rd_out(8'h28, 32'h0000_0040, "R10 base readback");

        // Spare attribute bits (R11)
        wr_out(8'h10, 32'hA0F5_500F);
        rd_out(8'h10, 32'hA0F5_500F, "R11 attr bits stored");
        lookup(44'h40010, 1'b1, 3'd0, 44'h100010, "R11 spare bits no effect");

        // Move window 0 (R12)
        wr_out(8'h08, 32'h0000_0060);
        lookup(44'h40010, 1'b1, 3'd1, 44'h240010, "R12 old mapping gone");
        lookup(44'h60010, 1'b1, 3'd0, 44'h100010, "R12 new mapping live");

        // Disable window 0 (R2)
        wr_out(8'h10, 32'h0000_000F);
        lookup(44'h60010, 1'b1, 3'd1, 44'h260010, "R2 disabled falls through");

        // Inbound build (R9)
        wr_in(8'h10, 32'h8000_000B);
        wr_in(8'h08, 32'h0000_0010);
        rd_in(8'h10, 32'h0, "R9 field 0 ignored");
        look_in(44'h10004, 1'b0, 3'd0, 44'h0, "R9 field 0 no window");
        wr_in(8'h20, 32'h0000_0500);
        wr_in(8'h28, 32'h0000_0010);
        wr_in(8'h30, 32'h8000_000B);
        look_in(44'h10004, 1'b1, 3'd0, 44'h500004, "R9 inbound window 0");
        wr_in(8'hE0, 32'h0000_0700);
        wr_in(8'hE8, 32'h0000_0020);
        wr_in(8'hF0, 32'h8000_000B);
        look_in(44'h20008, 1'b1, 3'd2, 44'h700008, "R9 inbound window 2 via bit 7");
        rd_in(8'h68, 32'h0000_0020, "R9 bit 7 alias readback");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule